// File: doc/BRIEF.md
# Host Controller Interrupt Status and Enable Controller

This block gathers the event pulses of a host controller into one interrupt line. Each supported event sets its own sticky bit in a status word. Software clears a bit by writing 1 to it. Hardware is the only source that sets a bit.

A separate enable word decides which status bits may raise the interrupt. Two offsets write that word. One offset can only set enable bits and the other can only clear them, so software never needs a read-modify-write. A global master enable sits on top of the per-event enables.

The frame-number overflow event has no pulse input of its own. The block finds it by watching the top bit of the frame counter.

Top module: `hc_irq_ctrl`

## Requirements
- R1: Each event pulse sets its status bit at the clock edge that samples it. The bit positions are: scheduling overrun bit 0, writeback done bit 1, start of frame bit 2, resume detected bit 3, ownership change bit 30. The status word reads at offset 0x0C in the same cycle as the set.
- R2: A set status bit stays set until software writes 1 to that bit at offset 0x0C. Writing 0 to a status bit leaves it unchanged.
- R3: Status bit 5 sets when the top bit of the frame number input differs from its value one cycle earlier. A change in either direction counts. A change in the lower bits does not set it. The first clock after reset only records the frame value and cannot set bit 5.
- R4: Status bit 6 sets on a hub status change pulse. It also sets on a change pulse from any downstream port.
- R5: Bit 4 reads as 0 at offsets 0x0C, 0x10 and 0x14, and writing 1 to it has no effect. Bits 29:7 read as 0 at those three offsets.
- R6: At offset 0x10, writing 1 to an enable bit sets that bit and writing 0 leaves it unchanged. The enable bits are master at bit 31, ownership change at bit 30, and bits 6:5 and 3:0.
- R7: At offset 0x14, writing 1 to a bit clears the matching enable bit. Writing 1 to bit 31 there clears the master enable.
- R8: Offsets 0x10 and 0x14 both read the current enable word. The enable word and the status word both reset to 0.
- R9: irq_o is registered. One cycle after the state changes, it equals: master enable AND (OR over all bits of status AND enable).
- R10: When an event sets a status bit in the same cycle that software clears it, the bit ends up set.
- R11: Any other offset reads 0. Writes to any other offset change neither the enable word nor the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_we_i | input | 1 | Write strobe, one write per cycle |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| evt_sched_ovr_i | input | 1 | Scheduling overrun pulse |
| evt_wb_done_i | input | 1 | Writeback done pulse |
| evt_sof_i | input | 1 | Start of frame pulse |
| evt_resume_i | input | 1 | Resume detected pulse |
| evt_own_chg_i | input | 1 | Ownership change pulse |
| evt_hub_chg_i | input | 1 | Hub status change pulse |
| evt_port_chg_i | input | NUM_PORTS | Per-port status change pulses |
| frame_num_i | input | FRAME_W | Current frame number |
| irq_o | output | 1 | Level interrupt request |

## Verification
Every state change is due one edge after its cause:
- Event pulses, frame-bit toggles and register writes reach the status and enable words at the edge that samples them.
- Those words are then readable in the same cycle through the combinational read port.
- irq_o lags them by one more edge.

The driver holds each stimulus for exactly one cycle. It queues each expected value so that the monitor compares it at the falling edge after the due edge. Latency-specific checks are queued without waiting. For example, the status bit is set while irq_o is still low in the cycle right after a pulse, and both are checked there. A second queued check then confirms irq_o one edge later.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;
  localparam int REG_W = 32;

  localparam int OFF_STAT = 'h0C;
  localparam int OFF_EN   = 'h10;
  localparam int OFF_DIS  = 'h14;

  localparam int BIT_SCHED = 0;
  localparam int BIT_WBD   = 1;
  localparam int BIT_SOF   = 2;
  localparam int BIT_RES   = 3;
  localparam int BIT_UNIMP = 4;
  localparam int BIT_FOVF  = 5;
  localparam int BIT_HUB   = 6;
  localparam int BIT_OWN   = 30;
  localparam int BIT_MIE   = 31;

  localparam logic [REG_W-1:0] STAT_MASK =
      (REG_W'(1) << BIT_SCHED) | (REG_W'(1) << BIT_WBD) | (REG_W'(1) << BIT_SOF) |
      (REG_W'(1) << BIT_RES)   | (REG_W'(1) << BIT_FOVF) | (REG_W'(1) << BIT_HUB) |
      (REG_W'(1) << BIT_OWN);
  localparam logic [REG_W-1:0] EN_MASK = STAT_MASK | (REG_W'(1) << BIT_MIE);
endpackage

// File: rtl/hc_irq_status.sv
module hc_irq_status
  import hc_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sched_ovr_i,
  input  logic                 wb_done_i,
  input  logic                 sof_i,
  input  logic                 resume_i,
  input  logic                 own_chg_i,
  input  logic                 hub_chg_i,
  input  logic [NUM_PORTS-1:0] port_chg_i,
  input  logic                 frame_msb_i,
  input  logic                 clr_we_i,
  input  logic [REG_W-1:0]     clr_data_i,
  output logic [REG_W-1:0]     status_o
);
  logic             msb_q, msb_vld_q, ovf_evt, any_port;
  logic [REG_W-1:0] set_vec, clr_vec, status_q;

  // msb_vld_q blocks a false toggle on the first clock after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msb_q     <= 1'b0;
      msb_vld_q <= 1'b0;
    end else begin
      msb_q     <= frame_msb_i;
      msb_vld_q <= 1'b1;
    end
  end

  assign ovf_evt  = msb_vld_q & (frame_msb_i ^ msb_q);
  assign any_port = |port_chg_i;

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_SCHED] = sched_ovr_i;
    set_vec[BIT_WBD]   = wb_done_i;
    set_vec[BIT_SOF]   = sof_i;
    set_vec[BIT_RES]   = resume_i;
    set_vec[BIT_FOVF]  = ovf_evt;
    set_vec[BIT_HUB]   = hub_chg_i | any_port;
    set_vec[BIT_OWN]   = own_chg_i;
    clr_vec            = clr_we_i ? clr_data_i : '0;
  end

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (set_vec | (status_q & ~clr_vec)) & STAT_MASK;
  end

  assign status_o = status_q;
endmodule

// File: rtl/hc_irq_enable.sv
module hc_irq_enable
  import hc_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] en_o
);
  logic [REG_W-1:0] en_q, set_bits, clr_bits;

  assign set_bits = set_we_i ? (wdata_i & EN_MASK) : '0;
  assign clr_bits = clr_we_i ? (wdata_i & EN_MASK) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q | set_bits) & ~clr_bits;
  end

  assign en_o = en_q;
endmodule

// File: rtl/hc_irq_out.sv
module hc_irq_out
  import hc_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  status_i,
  input  logic [REG_W-1:0]  en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    if (addr_i == ADDR_W'(OFF_STAT))
      rdata_o = status_i;
    else if (addr_i == ADDR_W'(OFF_EN) || addr_i == ADDR_W'(OFF_DIS))
      rdata_o = en_i;
    else
      rdata_o = '0;
  end

  assign irq_d = en_i[BIT_MIE] & (|(status_i & en_i & STAT_MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/hc_irq_ctrl.sv
module hc_irq_ctrl
  import hc_irq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_PORTS = 4,
  parameter int FRAME_W   = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic                 reg_we_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  input  logic                 evt_sched_ovr_i,
  input  logic                 evt_wb_done_i,
  input  logic                 evt_sof_i,
  input  logic                 evt_resume_i,
  input  logic                 evt_own_chg_i,
  input  logic                 evt_hub_chg_i,
  input  logic [NUM_PORTS-1:0] evt_port_chg_i,
  input  logic [FRAME_W-1:0]   frame_num_i,
  output logic                 irq_o
);
  localparam logic [FRAME_W-1:0] FRAME_MSB = FRAME_W'(1) << (FRAME_W - 1);

  logic [REG_W-1:0] status_q, en_q;
  logic             frame_msb, we_stat, we_en, we_dis;

  assign frame_msb = |(frame_num_i & FRAME_MSB);
  assign we_stat   = reg_we_i && (reg_addr_i == ADDR_W'(OFF_STAT));
  assign we_en     = reg_we_i && (reg_addr_i == ADDR_W'(OFF_EN));
  assign we_dis    = reg_we_i && (reg_addr_i == ADDR_W'(OFF_DIS));

  hc_irq_status #(.NUM_PORTS(NUM_PORTS)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sched_ovr_i (evt_sched_ovr_i),
    .wb_done_i   (evt_wb_done_i),
    .sof_i       (evt_sof_i),
    .resume_i    (evt_resume_i),
    .own_chg_i   (evt_own_chg_i),
    .hub_chg_i   (evt_hub_chg_i),
    .port_chg_i  (evt_port_chg_i),
    .frame_msb_i (frame_msb),
    .clr_we_i    (we_stat),
    .clr_data_i  (reg_wdata_i),
    .status_o    (status_q)
  );

  hc_irq_enable u_enable (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (we_en),
    .clr_we_i (we_dis),
    .wdata_i  (reg_wdata_i),
    .en_o     (en_q)
  );

  hc_irq_out #(.ADDR_W(ADDR_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_q),
    .en_i     (en_q),
    .addr_i   (reg_addr_i),
    .rdata_o  (reg_rdata_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/hc_irq_chk.sv
module hc_irq_chk
  import hc_irq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_PORTS = 4,
  parameter int FRAME_W   = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic                 reg_we_i,
  input logic [REG_W-1:0]     reg_wdata_i,
  input logic [REG_W-1:0]     reg_rdata_o,
  input logic                 evt_sched_ovr_i,
  input logic                 evt_sof_i,
  input logic [NUM_PORTS-1:0] evt_port_chg_i,
  input logic [FRAME_W-1:0]   frame_num_i,
  input logic [REG_W-1:0]     status_q,
  input logic [REG_W-1:0]     en_q,
  input logic                 irq_o
);
  logic f_msb_q, seen_q;
  logic wr_stat, wr_en, wr_dis, wr_other;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_msb_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      f_msb_q <= frame_num_i[FRAME_W-1];
      seen_q  <= 1'b1;
    end
  end

  assign wr_stat  = reg_we_i && reg_addr_i == ADDR_W'(OFF_STAT);
  assign wr_en    = reg_we_i && reg_addr_i == ADDR_W'(OFF_EN);
  assign wr_dis   = reg_we_i && reg_addr_i == ADDR_W'(OFF_DIS);
  assign wr_other = reg_we_i && !wr_stat && !wr_en && !wr_dis;

  p_evt_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_sched_ovr_i |=> status_q[BIT_SCHED]);

  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

  p_frame_ovf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && frame_num_i[FRAME_W-1] != f_msb_q) |=> status_q[BIT_FOVF]);

  p_port_chg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_port_chg_i) |=> status_q[BIT_HUB]);

  p_unimpl_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[BIT_UNIMP] == 1'b0) && (reg_rdata_o[29:7] == '0));

  p_en_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> ((en_q & $past(reg_wdata_i) & EN_MASK) == ($past(reg_wdata_i) & EN_MASK)));

  p_en_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dis |=> ((en_q & $past(reg_wdata_i)) == '0));

  p_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == ($past(en_q[BIT_MIE]) && (|($past(status_q) & $past(en_q) & STAT_MASK)))));

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_sof_i && wr_stat && reg_wdata_i[BIT_SOF]) |=> status_q[BIT_SOF]);

  p_other_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_other |=> (en_q == $past(en_q)));
endmodule

bind hc_irq_ctrl hc_irq_chk #(
  .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .FRAME_W(FRAME_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reg_addr_i      (reg_addr_i),
  .reg_we_i        (reg_we_i),
  .reg_wdata_i     (reg_wdata_i),
  .reg_rdata_o     (reg_rdata_o),
  .evt_sched_ovr_i (evt_sched_ovr_i),
  .evt_sof_i       (evt_sof_i),
  .evt_port_chg_i  (evt_port_chg_i),
  .frame_num_i     (frame_num_i),
  .status_q        (status_q),
  .en_q            (en_q),
  .irq_o           (irq_o)
);

// File: tb/sim_hc_irq_ctrl.sv
module sim_hc_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ev_so = 0, ev_wb = 0, ev_sof = 0, ev_res = 0, ev_own = 0, ev_hub = 0;
  logic [3:0]  ev_port = '0;
  logic [15:0] frame = 16'h8000;
  logic        irq;

  always #5 clk = ~clk;

  hc_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .evt_sched_ovr_i(ev_so), .evt_wb_done_i(ev_wb), .evt_sof_i(ev_sof),
    .evt_resume_i(ev_res), .evt_own_chg_i(ev_own), .evt_hub_chg_i(ev_hub),
    .evt_port_chg_i(ev_port), .frame_num_i(frame), .irq_o(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // monitor: compares one queued item per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t       it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {31'd0, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic rd_now(input logic [7:0] a, input logic [31:0] e, input string t);
    addr = a;
    q.push_back('{1'b0, e, t});
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    rd_now(a, e, t);
  endtask

  task automatic irq_now(input logic e, input string t);
    q.push_back('{1'b1, {31'd0, e}, t});
  endtask

  task automatic irq_chk(input logic e, input string t);
    @(posedge clk); #1;
    irq_now(e, t);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  // m: {hub, own, resume, sof, wb, sched}
  task automatic pulse(input logic [5:0] m, input logic [3:0] p);
    @(posedge clk); #1;
    {ev_hub, ev_own, ev_res, ev_sof, ev_wb, ev_so} = m;
    ev_port = p;
    @(posedge clk); #1;
    {ev_hub, ev_own, ev_res, ev_sof, ev_wb, ev_so} = '0;
    ev_port = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog on all requirements actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R8 / R3: reset values; frame msb high across reset is not an overflow
    rd(8'h0C, 32'h0, "R8 R3 status after reset");
    rd(8'h10, 32'h0, "R8 enable after reset");
    rd(8'h14, 32'h0, "R8 disable offset after reset");
    irq_chk(1'b0, "R9 irq after reset");

    pulse(6'b000001, 4'h0);
    rd(8'h0C, 32'h0000_0001, "R1 scheduling overrun");
    pulse(6'b011110, 4'h0);
    rd(8'h0C, 32'h4000_000F, "R1 wb/sof/resume/own");
    pulse(6'b100000, 4'h0);
    rd(8'h0C, 32'h4000_004F, "R4 hub change");
    wr(8'h0C, 32'h0000_0040);
    rd(8'h0C, 32'h4000_000F, "R2 clear hub bit");
    pulse(6'b000000, 4'b0100);
    rd(8'h0C, 32'h4000_004F, "R4 port change");

    wr(8'h0C, 32'h0);
    rd(8'h0C, 32'h4000_004F, "R2 write zero keeps bits");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0, "R2 clear all");
    wr(8'h10, 32'h0000_0010);
    rd(8'h10, 32'h0, "R5 bit4 enable ignored");

    @(posedge clk); #1; frame = 16'h0000;
    rd_now(8'h0C, 32'h0, "R3 no set before edge");
    rd(8'h0C, 32'h0000_0020, "R3 msb fall");
    wr(8'h0C, 32'h0000_0020);
    @(posedge clk); #1; frame = 16'h7FFF;
    rd(8'h0C, 32'h0, "R3 low bits only");
    @(posedge clk); #1; frame = 16'h8000;
    rd(8'h0C, 32'h0000_0020, "R3 msb rise");
    wr(8'h0C, 32'h0000_0020);

    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'hC000_006F, "R6 R5 enable set all");
    rd(8'h14, 32'hC000_006F, "R8 disable offset reads enable");
    rd(8'h0C, 32'h0, "R5 status reserved zero");
    wr(8'h10, 32'h0);
    rd(8'h10, 32'hC000_006F, "R6 write zero keeps");
    irq_chk(1'b0, "R9 no status no irq");

    pulse(6'b000100, 4'h0);
    irq_now(1'b0, "R9 irq one cycle later");
    rd_now(8'h0C, 32'h0000_0004, "R1 sof visible same cycle");
    irq_chk(1'b1, "R9 irq raised");
    wr(8'h14, 32'h8000_0000);
    rd_now(8'h10, 32'h4000_006F, "R7 master cleared");
    irq_chk(1'b0, "R9 master gates irq");
    wr(8'h10, 32'h8000_0000);
    irq_chk(1'b1, "R9 master restored");
    wr(8'h14, 32'h0000_0004);
    rd_now(8'h10, 32'hC000_006B, "R7 sof enable cleared");
    irq_chk(1'b0, "R9 masked source");

    @(posedge clk); #1;
    addr = 8'h0C; wdata = 32'h0000_0004; we = 1'b1; ev_sof = 1'b1;
    @(posedge clk); #1;
    we = 1'b0; ev_sof = 1'b0;
    rd_now(8'h0C, 32'h0000_0004, "R10 set beats clear");
    wr(8'h0C, 32'h0000_0004);
    rd(8'h0C, 32'h0, "R10 later clear works");

    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R11 unmapped reads zero");
    rd(8'h10, 32'hC000_006B, "R11 enable untouched");
    rd(8'h0C, 32'h0, "R11 status untouched");

    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule